// File: doc/BRIEF.md
# Electron/Photon Candidate Finder with Isolation

This block looks at one crossing's worth of calorimeter towers, a grid of 4 rows by 8 columns by default. Each tower carries an electromagnetic transverse energy, a hadronic transverse energy and a fine-grain bit. The fine-grain bit is set when the shower is narrow. The block picks out towers that are local EM maxima and pass the shape and hadronic-fraction cuts. For each such hit tower it builds a candidate energy. The candidate is then marked isolated or non-isolated from its 3x3 surroundings.

The grid is split into 4x4 regions along the column axis. For every region the block reports two candidates, each with an energy and a position inside the region: the strongest isolated one and the strongest non-isolated one. The whole grid and both thresholds are presented in parallel with a one-cycle strobe. Towers outside the grid count as empty and as passing every veto.

Top module: `egamma_iso_finder`

## Requirements
- R1: `out_valid` is high exactly 4 clock edges after the edge that samples `in_valid` high, and the outputs then belong to that crossing.
- R2: A tower is a hit tower only if its EM ET is at least `cfg_em_min`, strictly greater than its north (row-1) and west (column-1) neighbours, and greater than or equal to its south (row+1) and east (column+1) neighbours. Towers outside the grid count as EM 0.
- R3: A hit tower must satisfy HAD*8 <= EM.
- R4: A hit tower must have its fine-grain bit set to 1.
- R5: The candidate ET is the hit tower's EM plus the largest EM of its four edge neighbours, saturated at 1023.
- R6: A candidate can be isolated only if all eight surrounding towers have fine-grain = 1 and HAD*8 <= EM. Towers outside the grid count as passing.
- R7: An isolated candidate also needs at least one quiet group: five ring towers centred on one corner (that corner, plus the two towers on each side of it around the ring), each with EM below `cfg_quiet`.
- R8: Region k covers columns 4k..4k+3. It reports the largest isolated and the largest non-isolated candidate ET, with position row*4 + (column-4k). Each hit tower falls into exactly one of the two classes. An empty class reports ET 0 and position 0.
- R9: When candidate ETs tie within a region and class, the lower position is reported.
- R10: During and after reset, `out_valid` and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Crossing strobe, one cycle |
| tower_em | input | 320 | EM ET per tower, 10 bits each, tower index row*8+column |
| tower_had | input | 320 | Hadronic ET per tower, same layout |
| tower_fg | input | 32 | Fine-grain bit per tower, 1 = narrow shower |
| cfg_em_min | input | 10 | Minimum EM ET of a hit tower |
| cfg_quiet | input | 10 | Quiet threshold for neighbour EM ET |
| out_valid | output | 1 | Result strobe |
| iso_et | output | 20 | Best isolated ET per region, 10 bits each |
| iso_pos | output | 8 | Position of best isolated candidate per region, 4 bits each |
| non_et | output | 20 | Best non-isolated ET per region |
| non_pos | output | 8 | Position of best non-isolated candidate per region |

## Verification
The assertions assume that the thresholds stay constant while a crossing moves through the pipeline. The floor check compares an output against the registered `cfg_em_min`. The assertions also assume that `in_valid` is a clean 0/1 strobe. The bench changes thresholds only between crossings, after the previous result has come out. It raises `in_valid` for one cycle per crossing. The random grids are sparse: a few high towers sit on a low floor, so both isolated and non-isolated candidates, ties and vetoed towers all occur.

// File: rtl/egamma_iso_finder.sv
module egamma_iso_finder #(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  parameter int RW   = 4,
  parameter int EW   = 10,
  parameter int OW   = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [ROWS*COLS*EW-1:0]   tower_em,
  input  logic [ROWS*COLS*EW-1:0]   tower_had,
  input  logic [ROWS*COLS-1:0]      tower_fg,
  input  logic [EW-1:0]             cfg_em_min,
  input  logic [EW-1:0]             cfg_quiet,
  output logic                      out_valid,
  output logic [(COLS/RW)*OW-1:0]   iso_et,
  output logic [(COLS/RW)*$clog2(ROWS*RW)-1:0] iso_pos,
  output logic [(COLS/RW)*OW-1:0]   non_et,
  output logic [(COLS/RW)*$clog2(ROWS*RW)-1:0] non_pos
);
  localparam int NT   = ROWS * COLS;
  localparam int NREG = COLS / RW;
  localparam int PW   = $clog2(ROWS * RW);
  localparam int CAP  = (1 << OW) - 1;

  // stage 1: capture crossing
  logic [EW-1:0] em_q [NT];
  logic [EW-1:0] had_q [NT];
  logic [NT-1:0] fg_q;
  logic [EW-1:0] min_q, quiet_q;
  logic v1, v2, v3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin em_q[t] <= '0; had_q[t] <= '0; end
      fg_q <= '0; min_q <= '0; quiet_q <= '0; v1 <= 1'b0;
    end else begin
      for (int t = 0; t < NT; t++) begin
        em_q[t]  <= tower_em[t*EW +: EW];
        had_q[t] <= tower_had[t*EW +: EW];
      end
      fg_q <= tower_fg; min_q <= cfg_em_min; quiet_q <= cfg_quiet; v1 <= in_valid;
    end

  // stage 2: per-tower candidate
  logic [EW-1:0] emp [ROWS+2][COLS+2];
  logic          okp [ROWS+2][COLS+2];
  logic [OW-1:0] iso_c [NT];
  logic [OW-1:0] non_c [NT];

  always_comb begin
    for (int r = 0; r < ROWS + 2; r++)
      for (int c = 0; c < COLS + 2; c++) begin
        emp[r][c] = '0;
        okp[r][c] = 1'b1;
      end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        emp[r+1][c+1] = em_q[r*COLS+c];
        okp[r+1][c+1] = fg_q[r*COLS+c] &&
                        ({had_q[r*COLS+c], 3'b000} <= {3'b000, em_q[r*COLS+c]});
      end
  end

  always_comb begin : cand
    logic [EW-1:0] e, mx;
    logic [EW:0]   sum;
    logic [OW-1:0] cet;
    logic          hit, allok, iso;
    logic          qn, qne, qe, qse, qs, qsw, qw, qnw;
    for (int r = 1; r <= ROWS; r++)
      for (int c = 1; c <= COLS; c++) begin
        e   = emp[r][c];
        hit = okp[r][c] && (e >= min_q) && (e > emp[r-1][c]) && (e > emp[r][c-1])
              && (e >= emp[r+1][c]) && (e >= emp[r][c+1]);
        mx  = emp[r-1][c];
        if (emp[r+1][c] > mx) mx = emp[r+1][c];
        if (emp[r][c-1] > mx) mx = emp[r][c-1];
        if (emp[r][c+1] > mx) mx = emp[r][c+1];
        sum = {1'b0, e} + {1'b0, mx};
        cet = (32'(sum) > CAP) ? OW'(CAP) : OW'(sum);
        allok = okp[r-1][c-1] && okp[r-1][c] && okp[r-1][c+1] && okp[r][c+1]
             && okp[r+1][c+1] && okp[r+1][c] && okp[r+1][c-1] && okp[r][c-1];
        qn  = emp[r-1][c]   < quiet_q;  qne = emp[r-1][c+1] < quiet_q;
        qe  = emp[r][c+1]   < quiet_q;  qse = emp[r+1][c+1] < quiet_q;
        qs  = emp[r+1][c]   < quiet_q;  qsw = emp[r+1][c-1] < quiet_q;
        qw  = emp[r][c-1]   < quiet_q;  qnw = emp[r-1][c-1] < quiet_q;
        iso = allok && ((qnw && qn && qne && qe && qse) || (qne && qe && qse && qs && qsw)
                     || (qse && qs && qsw && qw && qnw) || (qsw && qw && qnw && qn && qne));
        iso_c[(r-1)*COLS+c-1] = (hit && iso)  ? cet : '0;
        non_c[(r-1)*COLS+c-1] = (hit && !iso) ? cet : '0;
      end
  end

  logic [OW-1:0] iso_q [NT];
  logic [OW-1:0] non_q [NT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin iso_q[t] <= '0; non_q[t] <= '0; end
      v2 <= 1'b0;
    end else begin
      for (int t = 0; t < NT; t++) begin iso_q[t] <= iso_c[t]; non_q[t] <= non_c[t]; end
      v2 <= v1;
    end

  // stage 3: best per region row; stage 4: best per region
  logic [OW-1:0] ri_et [NREG*ROWS];
  logic [OW-1:0] rn_et [NREG*ROWS];
  logic [PW-1:0] ri_pos [NREG*ROWS];
  logic [PW-1:0] rn_pos [NREG*ROWS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG*ROWS; i++) begin
        ri_et[i] <= '0; rn_et[i] <= '0; ri_pos[i] <= '0; rn_pos[i] <= '0;
      end
      v3 <= 1'b0;
    end else begin
      for (int k = 0; k < NREG; k++)
        for (int r = 0; r < ROWS; r++) begin : row_pick
          logic [OW-1:0] bi, bn;
          logic [PW-1:0] pi, pn;
          bi = '0; bn = '0; pi = '0; pn = '0;
          for (int c = 0; c < RW; c++) begin
            if (iso_q[r*COLS+k*RW+c] > bi) begin bi = iso_q[r*COLS+k*RW+c]; pi = PW'(r*RW+c); end
            if (non_q[r*COLS+k*RW+c] > bn) begin bn = non_q[r*COLS+k*RW+c]; pn = PW'(r*RW+c); end
          end
          ri_et[k*ROWS+r] <= bi; ri_pos[k*ROWS+r] <= pi;
          rn_et[k*ROWS+r] <= bn; rn_pos[k*ROWS+r] <= pn;
        end
      v3 <= v2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      iso_et <= '0; iso_pos <= '0; non_et <= '0; non_pos <= '0; out_valid <= 1'b0;
    end else begin
      for (int k = 0; k < NREG; k++) begin : reg_pick
        logic [OW-1:0] bi, bn;
        logic [PW-1:0] pi, pn;
        bi = '0; bn = '0; pi = '0; pn = '0;
        for (int r = 0; r < ROWS; r++) begin
          if (ri_et[k*ROWS+r] > bi) begin bi = ri_et[k*ROWS+r]; pi = ri_pos[k*ROWS+r]; end
          if (rn_et[k*ROWS+r] > bn) begin bn = rn_et[k*ROWS+r]; pn = rn_pos[k*ROWS+r]; end
        end
        iso_et[k*OW +: OW] <= bi; iso_pos[k*PW +: PW] <= pi;
        non_et[k*OW +: OW] <= bn; non_pos[k*PW +: PW] <= pn;
      end
      out_valid <= v3;
    end

  // assertions
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 3'd4) age <= age + 3'd1;

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  for (genvar t = 0; t < NT; t++) begin : g_tower_chk
    // R4 is covered here too: fine-grain must be set
    assert_veto_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (iso_q[t] != '0 || non_q[t] != '0) |->
        $past(fg_q[t] && ({had_q[t], 3'b000} <= {3'b000, em_q[t]})));
    assert_one_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(iso_q[t] != '0 && non_q[t] != '0));
    assert_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (iso_q[t] != '0 || non_q[t] != '0) |->
        (32'(iso_q[t]) + 32'(non_q[t]) >= 32'($past(min_q))));
  end

  for (genvar k = 0; k < NREG; k++) begin : g_region_chk
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assert_region_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_et[k*OW +: OW] >= $past(ri_et[k*ROWS+r])) &&
        (non_et[k*OW +: OW] >= $past(rn_et[k*ROWS+r])));
    end
  end
endmodule

// File: tb/egamma_iso_finder_bench.sv
module egamma_iso_finder_bench;
  localparam int ROWS = 4, COLS = 8, EW = 10, OW = 10, NREG = 2, PW = 4;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [ROWS*COLS*EW-1:0] tower_em = '0, tower_had = '0;
  logic [ROWS*COLS-1:0] tower_fg = '0;
  logic [EW-1:0] cfg_em_min = '0, cfg_quiet = '0;
  logic out_valid;
  logic [NREG*OW-1:0] iso_et, non_et;
  logic [NREG*PW-1:0] iso_pos, non_pos;

  egamma_iso_finder u_egamma_iso_finder (.*);

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  int em [ROWS][COLS], had [ROWS][COLS], fg [ROWS][COLS];
  int em_min, quiet;
  int x_iet [NREG], x_ipos [NREG], x_net [NREG], x_npos [NREG];

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gem(int r, int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 0;
    return em[r][c];
  endfunction
  function automatic int gok(int r, int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 1;
    return (fg[r][c] != 0 && had[r][c] * 8 <= em[r][c]) ? 1 : 0;
  endfunction
  function automatic int q(int r, int c);
    return (gem(r, c) < quiet) ? 1 : 0;
  endfunction

  function automatic void model();
    for (int k = 0; k < NREG; k++) begin x_iet[k] = 0; x_ipos[k] = 0; x_net[k] = 0; x_npos[k] = 0; end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int e, mx, cet, ok8, g, k, p;
        e = em[r][c];
        if (!(gok(r, c) != 0 && e >= em_min && e > gem(r-1, c) && e > gem(r, c-1)
              && e >= gem(r+1, c) && e >= gem(r, c+1))) continue;
        mx = gem(r-1, c);
        if (gem(r+1, c) > mx) mx = gem(r+1, c);
        if (gem(r, c-1) > mx) mx = gem(r, c-1);
        if (gem(r, c+1) > mx) mx = gem(r, c+1);
        cet = (e + mx > 1023) ? 1023 : e + mx;
        ok8 = gok(r-1,c-1) & gok(r-1,c) & gok(r-1,c+1) & gok(r,c+1)
            & gok(r+1,c+1) & gok(r+1,c) & gok(r+1,c-1) & gok(r,c-1);
        g = (q(r-1,c-1) & q(r-1,c) & q(r-1,c+1) & q(r,c+1) & q(r+1,c+1))
          | (q(r-1,c+1) & q(r,c+1) & q(r+1,c+1) & q(r+1,c) & q(r+1,c-1))
          | (q(r+1,c+1) & q(r+1,c) & q(r+1,c-1) & q(r,c-1) & q(r-1,c-1))
          | (q(r+1,c-1) & q(r,c-1) & q(r-1,c-1) & q(r-1,c) & q(r-1,c+1));
        k = c / 4;
        p = r * 4 + (c % 4);
        if (ok8 != 0 && g != 0) begin
          if (cet > x_iet[k]) begin x_iet[k] = cet; x_ipos[k] = p; end
        end else begin
          if (cet > x_net[k]) begin x_net[k] = cet; x_npos[k] = p; end
        end
      end
  endfunction

  task automatic clear_grid();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin em[r][c] = 0; had[r][c] = 0; fg[r][c] = 1; end
  endtask

  task automatic run(string tag);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        tower_em[(r*COLS+c)*EW +: EW]  = EW'(em[r][c]);
        tower_had[(r*COLS+c)*EW +: EW] = EW'(had[r][c]);
        tower_fg[r*COLS+c] = fg[r][c][0];
      end
    cfg_em_min = EW'(em_min);
    cfg_quiet  = EW'(quiet);
    model();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({tag, " R1 early"}, int'(out_valid), 0);
    @(negedge clk);
    chk({tag, " R1 valid"}, int'(out_valid), 1);
    for (int k = 0; k < NREG; k++) begin
      chk({tag, " iso_et"},  int'(iso_et[k*OW +: OW]),  x_iet[k]);
      chk({tag, " iso_pos"}, int'(iso_pos[k*PW +: PW]), x_ipos[k]);
      chk({tag, " non_et"},  int'(non_et[k*OW +: OW]),  x_net[k]);
      chk({tag, " non_pos"}, int'(non_pos[k*PW +: PW]), x_npos[k]);
    end
    @(negedge clk);
    chk({tag, " R1 single"}, int'(out_valid), 0);
  endtask

  initial begin
    #4000000;
    nerr++; nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    em_min = 4; quiet = 10;
    clear_grid();
    repeat (3) @(negedge clk);
    chk("R10 reset valid", int'(out_valid), 0);
    chk("R10 reset iso", int'(iso_et), 0);
    chk("R10 reset non", int'(non_et), 0);
    rst_n = 1'b1;
    @(negedge clk);

    clear_grid(); em[1][1] = 1000; em[1][2] = 900;
    run("R5 saturate");
    chk("R5 sat value", int'(iso_et[OW-1:0]), 1023);

    clear_grid(); em[0][0] = 50; em[2][2] = 50;
    run("R9 tie");
    chk("R9 tie pos", int'(iso_pos[PW-1:0]), 0);

    clear_grid(); em[1][1] = 80; had[1][1] = 10; em[1][5] = 80; had[1][5] = 11;
    run("R3 ratio");
    chk("R3 edge pass", int'(iso_et[OW-1:0]), 80);
    chk("R3 edge fail", int'(iso_et[2*OW-1:OW]), 0);

    clear_grid(); em[2][1] = 90; fg[2][1] = 0;
    run("R4 shape");
    chk("R4 no cand", int'(iso_et[OW-1:0]) + int'(non_et[OW-1:0]), 0);

    clear_grid(); em[1][6] = 100; fg[2][7] = 0;
    run("R6 neighbour veto");
    chk("R6 nonisolated", int'(non_et[2*OW-1:OW]), 100);

    clear_grid(); em[1][1] = 100; em[0][1] = 20; em[1][2] = 20; em[2][1] = 20; em[1][0] = 20;
    run("R7 no quiet group");
    chk("R7 nonisolated", int'(non_et[OW-1:0]), 120);
    chk("R7 iso empty", int'(iso_et[OW-1:0]), 0);

    clear_grid(); em_min = 40; em[1][1] = 30; em[2][5] = 60; em[2][6] = 60;
    run("R2 local max");
    chk("R2 below min", int'(iso_et[OW-1:0]), 0);
    chk("R2 east tie", int'(iso_pos[2*PW-1:PW]), 9);

    for (int n = 0; n < 400; n++) begin
      em_min = $urandom_range(0, 40);
      quiet  = $urandom_range(4, 64);
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          em[r][c]  = ($urandom_range(0, 99) < 18) ? $urandom_range(0, 1023) : $urandom_range(0, 6);
          had[r][c] = ($urandom_range(0, 99) < 80) ? em[r][c] / $urandom_range(6, 40)
                                                    : $urandom_range(0, 200);
          fg[r][c]  = ($urandom_range(0, 99) < 90) ? 1 : 0;
        end
      run("R8 random");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule